// File: doc/BRIEF.md
# Teletype-Style Serial Transmitter with Reload Divider

This block sends one byte at a time over an asynchronous serial line. It runs from a fixed reference clock, nominally 5 MHz. A free-running 16-bit up-counter reloads a preset value every time it passes its all-ones state, and that event is a divider tick. The tick period is therefore 65536 minus the preset, in reference clocks. The frame shifter holds every serial bit for two ticks, so the line rate is half the tick rate. A preset of 57203 gives ticks at about 600 Hz and a line rate of 300 bit/s.

The host places a byte on the data input, chooses one or two stop bits, and pulses the load strobe. The byte goes out framed as a low start bit, eight data bits least significant bit first, and one or two high stop bits. When the last stop bit has ended, a completion flag rises, and the host polls it. A new load clears the flag, and so does a dedicated clear input, which does not send anything.

Top module: `tty_tx`

## Requirements
- R1: While reset is asserted and after it is released, the serial line is 1 and the completion flag is 0 until a frame is loaded.
- R2: The divider produces one tick every 65536 minus PRESET reference clocks, and its count never falls below PRESET.
- R3: A frame is a start bit of 0, then data bits 0 through 7 in that order, then stop bits of 1. There are two stop bits when the stop select input is 1 at load and one stop bit when it is 0, so a frame is 11 or 10 bits long.
- R4: Every bit of a frame is held on the line for exactly 2 × (65536 − PRESET) reference clocks.
- R5: The start bit begins on the first divider tick after the load. This is between 1 and 65536 − PRESET clocks after the load edge.
- R6: The completion flag stays 0 during a frame. It rises on the same clock edge on which the last stop bit ends.
- R7: A load strobe accepted while idle clears the completion flag on its capture edge.
- R8: A load strobe that arrives while a frame is waiting or sending has no effect on the data, the stop count or the timing of that frame.
- R9: A pulse on the clear input sets the completion flag to 0 and leaves the line idle at 1.
- R10: Between frames the line is held at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tx_data | input | 8 | Byte to send, captured on load |
| tx_load | input | 1 | One-cycle strobe that starts a frame when idle |
| two_stop | input | 1 | 1 selects two stop bits, 0 selects one; captured on load |
| done_clr | input | 1 | One-cycle strobe that clears the completion flag |
| txd | output | 1 | Serial line, idle high |
| done | output | 1 | Completion flag, set when a frame has finished |

## Verification
Assertions check several properties on every cycle: the divider count stays at or above its preset, each armed frame begins with a low start bit, the flag rises only when leaving the sending state, and loads and clears act on the flag as specified. A load during a frame must leave the frame contents unchanged, and an assertion checks that too. Only the bench scenarios can show the exact bit durations, the full bit order for every byte value with both stop counts, and the start latency measured from the load edge. The bench sweeps all 256 byte values with both stop settings and a small preset, and it injects stray loads into a share of the frames.

// File: rtl/tty_tx_pkg.sv
package tty_tx_pkg;
  localparam int DATA_W  = 8;
  localparam int CNT_W   = 16;
  localparam int FRAME_W = DATA_W + 3;           // start + data + two stop
  localparam int BITS_W  = $clog2(FRAME_W + 1);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARM  = 2'd1,
    ST_SEND = 2'd2
  } tx_state_t;
endpackage

// File: rtl/tty_tx_div.sv
module tty_tx_div #(
  parameter int           CNT_W  = 16,
  parameter logic [15:0]  PRESET = 16'd57203
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam logic [CNT_W-1:0] LOAD_V = CNT_W'(PRESET);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign tick = &cnt_q;

  always_comb begin
    if (tick) cnt_d = LOAD_V;
    else      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= LOAD_V;
    else        cnt_q <= cnt_d;
  end

  // R2
  cnt_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q >= LOAD_V);
endmodule

// File: rtl/tty_tx_frame.sv
module tty_tx_frame
  import tty_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              ld,
  input  logic [DATA_W-1:0] data,
  input  logic              two_stop,
  input  logic              clr,
  output logic              txd,
  output logic              done
);
  localparam logic [BITS_W-1:0] NB_ONE = BITS_W'(FRAME_W - 1);
  localparam logic [BITS_W-1:0] NB_TWO = BITS_W'(FRAME_W);

  tx_state_t          state_q, state_d;
  logic [FRAME_W-1:0] shreg_q, shreg_d;
  logic [BITS_W-1:0]  bits_q, bits_d;
  logic               phase_q, phase_d;
  logic               done_q, done_d;

  always_comb begin
    state_d = state_q;
    shreg_d = shreg_q;
    bits_d  = bits_q;
    phase_d = phase_q;
    done_d  = done_q;
    if (clr) done_d = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (ld) begin
          shreg_d = {2'b11, data, 1'b0};
          bits_d  = two_stop ? NB_TWO : NB_ONE;
          phase_d = 1'b0;
          done_d  = 1'b0;
          state_d = ST_ARM;
        end
      end
      ST_ARM: begin
        if (tick) state_d = ST_SEND;
      end
      ST_SEND: begin
        if (tick) begin
          phase_d = ~phase_q;
          if (phase_q) begin
            shreg_d = {1'b1, shreg_q[FRAME_W-1:1]};
            bits_d  = bits_q - 1'b1;
            if (bits_q == BITS_W'(1)) begin
              state_d = ST_IDLE;
              done_d  = 1'b1;
            end
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      shreg_q <= '1;
      bits_q  <= '0;
      phase_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      shreg_q <= shreg_d;
      bits_q  <= bits_d;
      phase_q <= phase_d;
      done_q  <= done_d;
    end
  end

  assign txd  = (state_q == ST_SEND) ? shreg_q[0] : 1'b1;
  assign done = done_q;

  // R3
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ARM && tick) |=> (txd == 1'b0));

  // R6
  done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $past(state_q == ST_SEND));

  // R6
  busy_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |-> !done_q);

  // R7
  load_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && ld) |=> !done_q);

  // R8
  busy_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ARM && ld && !tick) |=> ($stable(shreg_q) && $stable(bits_q)));

  // R9
  clr_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && state_q == ST_IDLE && !ld) |=> (!done_q && state_q == ST_IDLE));
endmodule

// File: rtl/tty_tx.sv
module tty_tx
  import tty_tx_pkg::*;
#(
  parameter logic [15:0] PRESET = 16'd57203
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] tx_data,
  input  logic       tx_load,
  input  logic       two_stop,
  input  logic       done_clr,
  output logic       txd,
  output logic       done
);
  logic rst_meta_q, rst_sync_q;
  logic tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  tty_tx_div #(
    .CNT_W  (CNT_W),
    .PRESET (PRESET)
  ) u_div (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .tick  (tick)
  );

  tty_tx_frame u_frame (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .tick     (tick),
    .ld       (tx_load),
    .data     (tx_data),
    .two_stop (two_stop),
    .clr      (done_clr),
    .txd      (txd),
    .done     (done)
  );
endmodule

// File: tb/sim_tty_tx.sv
`timescale 1ns/1ps
module sim_tty_tx;
  localparam logic [15:0] PRE = 16'd65533;
  localparam int D  = 65536 - int'(PRE);   // clocks per tick
  localparam int BT = 2 * D;               // clocks per bit

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] tx_data;
  logic       tx_load, two_stop, done_clr;
  logic       txd, done;

  int tests  = 0;
  int failed = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  tty_tx #(.PRESET(PRE)) u0 (
    .clk(clk), .rst_n(rst_n), .tx_data(tx_data), .tx_load(tx_load),
    .two_stop(two_stop), .done_clr(done_clr), .txd(txd), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      failed++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic exp_bit(input logic [7:0] d, input int k);
    if (k == 0) return 1'b0;
    if (k <= 8) return d[k-1];
    return 1'b1;
  endfunction

  task automatic send(input logic [7:0] d, input bit two, input bit intrude);
    int n;
    int nb;
    nb = two ? 11 : 10;
    @(negedge clk);
    tx_data = d; two_stop = two; tx_load = 1'b1;
    @(negedge clk);
    tx_load = 1'b0;
    chk(done == 1'b0, "R7 load clears flag", int'(done), 0);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (txd !== 1'b0 && n <= D);
    chk(n >= 1 && n <= D, "R5 start latency", n, D);
    for (int idx = 0; idx < nb * BT; idx++) begin
      if (idx > 0) @(negedge clk);
      // R2, R4: bit k spans clocks k*BT .. k*BT+BT-1 after the start edge
      chk(txd == exp_bit(d, idx / BT), "R3/R4 line bit", int'(txd), int'(exp_bit(d, idx / BT)));
      chk(done == 1'b0, "R6 flag low in frame", int'(done), 0);
      if (intrude && idx == D) begin
        tx_load = 1'b1; tx_data = ~d; two_stop = ~two;   // R8
      end
      if (intrude && idx == D + 1) tx_load = 1'b0;
    end
    @(negedge clk);
    chk(txd == 1'b1, "R10 idle after frame", int'(txd), 1);
    chk(done == 1'b1, "R6 flag at frame end", int'(done), 1);
  endtask

  initial begin
    rst_n = 1'b0; tx_data = '0; tx_load = 1'b0; two_stop = 1'b0; done_clr = 1'b0;
    repeat (3) @(negedge clk);
    chk(txd == 1'b1, "R1 line in reset", int'(txd), 1);
    chk(done == 1'b0, "R1 flag in reset", int'(done), 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(txd == 1'b1, "R1 line after reset", int'(txd), 1);
    chk(done == 1'b0, "R1 flag after reset", int'(done), 0);

    for (int dv = 0; dv < 256; dv++)
      for (int tw = 0; tw < 2; tw++)
        send(8'(dv), bit'(tw), (dv % 16) == 5);

    // R9: clear without a new frame
    @(negedge clk);
    done_clr = 1'b1;
    @(negedge clk);
    done_clr = 1'b0;
    chk(done == 1'b0, "R9 clear drops flag", int'(done), 1'b0);
    for (int i = 0; i < 4 * BT; i++) begin
      @(negedge clk);
      chk(txd == 1'b1, "R9 no frame after clear", int'(txd), 1);
    end

    // R7 after clear path: one more frame, then flag returns
    send(8'hA5, 1'b1, 1'b1);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      tests++;
      failed++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", tests, failed);
      $finish;
    end
  end
endmodule